// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a 32-bit processor core into an exception handler. It watches seven request sources: reset, undefined instruction, software interrupt, prefetch abort, data abort, and the two active-low interrupt lines, normal and fast. It also sees the live status word and the address of the instruction after the current one. When a request is accepted, it picks one winner by fixed priority and captures the status word and the next address.

It then runs a three-step entry. In the first step it writes the old status word into the saved status register of the target mode. In the second it writes the new status word and puts the return address into the link register of the target mode. In the third it loads the fixed vector into fetch and flushes the pipeline for one cycle. The register file and the fetch unit act on the strobes; the block holds no registers that software can see.

For the return path the block only gives one combinational flag. The flag marks a status restore that is attempted apart from the PC load. Such a restore would switch the banked link register away before the return address is used.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `spsr_we`, `cpsr_we`, `lr_we`, `pc_load`, `flush` and `busy` are all 0.
- R2: `pc_target` equals VEC_BASE plus a fixed offset per source: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C (VEC_BASE defaults to 0).
- R3: The target mode, shown on `spsr_mode`, `lr_mode` and `cpsr_data[4:0]`, is 5'b10011 (supervisor) for reset and software interrupt, 5'b10111 (abort) for both aborts, 5'b11011 (undefined) for undefined, 5'b10010 for the normal interrupt and 5'b10001 for the fast interrupt.
- R4: Reset is accepted in any idle cycle. Every other request is accepted only in an idle cycle with `instr_done` high. Nothing is accepted while `busy` is 1.
- R5: For a request accepted at clock edge N, `spsr_we` is 1 in the cycle after N, `cpsr_we` and `lr_we` are 1 in the cycle after that, and `pc_load` and `flush` are 1 in the third cycle. Each is a one-cycle pulse. `busy` is 1 for exactly those three cycles.
- R6: `spsr_data` is the `cpsr_in` value sampled at acceptance, and `lr_data` is the `next_pc` value sampled at acceptance.
- R7: `cpsr_data` is the captured status word with bits [4:0] set to the target mode. Bit 7 (normal interrupt mask) is set to 1 and bit 5 (compact-instruction state) is cleared to 0. Bit 6 (fast interrupt mask) is set to 1 for the fast interrupt and kept otherwise. All other bits are kept.
- R8: `irq_n` and `fiq_n` request when low. A normal interrupt is ignored while `cpsr_in[7]` is 1, and a fast interrupt is ignored while `cpsr_in[6]` is 1.
- R9: Among accepted requests the winner is, from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R10: `restore_conflict` is 1 exactly when `restore_psr` is 1 and `restore_pc` is 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| instr_done | input | 1 | Current instruction finishes this cycle |
| exc_reset | input | 1 | Reset exception request |
| exc_undef | input | 1 | Undefined-instruction request |
| exc_swi | input | 1 | Software-interrupt request |
| exc_pabt | input | 1 | Prefetch-abort request |
| exc_dabt | input | 1 | Data-abort request |
| irq_n | input | 1 | Normal interrupt, active low |
| fiq_n | input | 1 | Fast interrupt, active low |
| cpsr_in | input | 32 | Current status word |
| next_pc | input | 32 | Address of the following instruction |
| restore_psr | input | 1 | Return path restores status from the saved copy |
| restore_pc | input | 1 | Return path loads the return address in the same cycle |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_mode | output | 5 | Mode whose saved status is written |
| spsr_data | output | 32 | Saved-status write data |
| cpsr_we | output | 1 | Current-status write strobe |
| cpsr_data | output | 32 | New current status word |
| lr_we | output | 1 | Link-register write strobe |
| lr_mode | output | 5 | Bank of the link register written |
| lr_data | output | 32 | Return address |
| pc_load | output | 1 | Load `pc_target` into fetch |
| pc_target | output | 32 | Vector address |
| flush | output | 1 | One-cycle pipeline flush |
| busy | output | 1 | Entry sequence in progress |
| restore_conflict | output | 1 | Status restore issued apart from PC load |

## Verification
Directed cases drive two or more sources together: all seven, data abort with fast interrupt, fast with normal interrupt, normal interrupt with prefetch abort, and undefined with software interrupt. Each of these pairs separates one adjacent step of the priority order. Other directed cases pair a request with `instr_done` low, which tells reset apart from the sources that wait for the instruction to finish. They also combine each interrupt with each mask bit, which shows that each line answers only to its own mask. Random rounds mix sparse request sets, random status words with random mask and T bits, and random return addresses. These rounds catch swapped capture data, a wrong mode or vector per source, and lost or extra status bits across the whole three-step sequence.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int DATA_W = 32;
  localparam int MODE_W = 5;
  localparam int SLOT_SHIFT = 2;

  // enum value is the vector slot index
  typedef enum logic [2:0] {
    EK_RESET = 3'd0, EK_UNDEF = 3'd1, EK_SWI = 3'd2, EK_PABT = 3'd3,
    EK_DABT  = 3'd4, EK_RSVD  = 3'd5, EK_IRQ = 3'd6, EK_FIQ  = 3'd7
  } exc_kind_e;

  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  function automatic logic [MODE_W-1:0] mode_of(exc_kind_e k);
    case (k)
      EK_FIQ:            return M_FIQ;
      EK_IRQ:            return M_IRQ;
      EK_PABT, EK_DABT:  return M_ABT;
      EK_UNDEF:          return M_UND;
      default:           return M_SVC;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] vector_of(exc_kind_e k,
                                                   logic [DATA_W-1:0] base);
    return base + (DATA_W'(k) << SLOT_SHIFT);
  endfunction

  function automatic logic [DATA_W-1:0] entry_psr(logic [DATA_W-1:0] old,
                                                   exc_kind_e k);
    logic [DATA_W-1:0] n;
    n = old;
    n[MODE_W-1:0] = mode_of(k);
    n[BIT_I] = 1'b1;
    n[BIT_T] = 1'b0;
    if (k == EK_FIQ) n[BIT_F] = 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/exc_prio_arb.sv
`timescale 1ns/1ps
module exc_prio_arb
  import exc_pkg::*;
(
  input  logic      instr_done,
  input  logic      rq_reset,
  input  logic      rq_undef,
  input  logic      rq_swi,
  input  logic      rq_pabt,
  input  logic      rq_dabt,
  input  logic      irq_n,
  input  logic      fiq_n,
  input  logic      mask_i,
  input  logic      mask_f,
  output logic      win_valid,
  output exc_kind_e win_kind
);
  logic irq_live, fiq_live, sync_any;

  assign irq_live = ~irq_n & ~mask_i;
  assign fiq_live = ~fiq_n & ~mask_f;
  assign sync_any = rq_undef | rq_swi | rq_pabt | rq_dabt | irq_live | fiq_live;
  assign win_valid = rq_reset | (instr_done & sync_any);

  always_comb begin
    if (rq_reset)      win_kind = EK_RESET;
    else if (rq_dabt)  win_kind = EK_DABT;
    else if (fiq_live) win_kind = EK_FIQ;
    else if (irq_live) win_kind = EK_IRQ;
    else if (rq_pabt)  win_kind = EK_PABT;
    else if (rq_undef) win_kind = EK_UNDEF;
    else               win_kind = EK_SWI;
  end
endmodule

// File: rtl/exc_seq_fsm.sv
`timescale 1ns/1ps
module exc_seq_fsm
  import exc_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  exc_kind_e         kind_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [DATA_W-1:0] pc_in,
  output logic              spsr_we,
  output logic [MODE_W-1:0] spsr_mode,
  output logic [DATA_W-1:0] spsr_data,
  output logic              cpsr_we,
  output logic [DATA_W-1:0] cpsr_data,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [DATA_W-1:0] lr_data,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_target,
  output logic              flush,
  output logic              busy
);
  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_SWITCH, S_JUMP} seq_e;
  seq_e              state;
  exc_kind_e         kind_q;
  logic [DATA_W-1:0] psr_q, pc_q;
  logic [MODE_W-1:0] tgt_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= EK_RESET;
      psr_q  <= '0;
      pc_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_SAVE;
          kind_q <= kind_in;
          psr_q  <= psr_in;
          pc_q   <= pc_in;
        end
        S_SAVE:   state <= S_SWITCH;
        S_SWITCH: state <= S_JUMP;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign tgt_mode  = mode_of(kind_q);
  assign busy      = (state != S_IDLE);
  // old status saved one cycle before the mode switch
  assign spsr_we   = (state == S_SAVE);
  assign spsr_mode = tgt_mode;
  assign spsr_data = psr_q;
  assign cpsr_we   = (state == S_SWITCH);
  assign cpsr_data = entry_psr(psr_q, kind_q);
  assign lr_we     = (state == S_SWITCH);
  assign lr_mode   = tgt_mode;
  assign lr_data   = pc_q;
  assign pc_load   = (state == S_JUMP);
  assign flush     = (state == S_JUMP);
  assign pc_target = vector_of(kind_q, VEC_BASE);
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              exc_reset,
  input  logic              exc_undef,
  input  logic              exc_swi,
  input  logic              exc_pabt,
  input  logic              exc_dabt,
  input  logic              irq_n,
  input  logic              fiq_n,
  input  logic [DATA_W-1:0] cpsr_in,
  input  logic [DATA_W-1:0] next_pc,
  input  logic              restore_psr,
  input  logic              restore_pc,
  output logic              spsr_we,
  output logic [MODE_W-1:0] spsr_mode,
  output logic [DATA_W-1:0] spsr_data,
  output logic              cpsr_we,
  output logic [DATA_W-1:0] cpsr_data,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [DATA_W-1:0] lr_data,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_target,
  output logic              flush,
  output logic              busy,
  output logic              restore_conflict
);
  logic      win_valid;
  exc_kind_e win_kind;
  logic      accept_evt;

  exc_prio_arb u_arb (
    .instr_done (instr_done),
    .rq_reset   (exc_reset),
    .rq_undef   (exc_undef),
    .rq_swi     (exc_swi),
    .rq_pabt    (exc_pabt),
    .rq_dabt    (exc_dabt),
    .irq_n      (irq_n),
    .fiq_n      (fiq_n),
    .mask_i     (cpsr_in[BIT_I]),
    .mask_f     (cpsr_in[BIT_F]),
    .win_valid  (win_valid),
    .win_kind   (win_kind)
  );

  assign accept_evt = win_valid & ~busy;

  exc_seq_fsm #(.VEC_BASE(VEC_BASE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_evt),
    .kind_in   (win_kind),
    .psr_in    (cpsr_in),
    .pc_in     (next_pc),
    .spsr_we   (spsr_we),
    .spsr_mode (spsr_mode),
    .spsr_data (spsr_data),
    .cpsr_we   (cpsr_we),
    .cpsr_data (cpsr_data),
    .lr_we     (lr_we),
    .lr_mode   (lr_mode),
    .lr_data   (lr_data),
    .pc_load   (pc_load),
    .pc_target (pc_target),
    .flush     (flush),
    .busy      (busy)
  );

  // restoring status alone would bank out the link register holding the return
  assign restore_conflict = restore_psr & ~restore_pc;
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              spsr_we,
  input logic [MODE_W-1:0] spsr_mode,
  input logic              cpsr_we,
  input logic [DATA_W-1:0] cpsr_data,
  input logic              lr_we,
  input logic [MODE_W-1:0] lr_mode,
  input logic              pc_load,
  input logic              flush,
  input logic              busy
);
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spsr_we, cpsr_we, pc_load}));
  p_accept_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> spsr_we);
  p_save_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |-> $past(spsr_we));
  p_jump_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ($past(cpsr_we) && flush));
  p_flush_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  p_save_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> busy);
  p_lr_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |-> (lr_we && lr_mode == cpsr_data[MODE_W-1:0]));
  p_mode_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |-> (cpsr_data[MODE_W-1:0] == $past(spsr_mode)));
  p_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |-> (cpsr_data[BIT_I] && !cpsr_data[BIT_T]));
  p_fiq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_we && cpsr_data[MODE_W-1:0] == M_FIQ) |-> cpsr_data[BIT_F]);
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept_evt),
  .spsr_we   (spsr_we),
  .spsr_mode (spsr_mode),
  .cpsr_we   (cpsr_we),
  .cpsr_data (cpsr_data),
  .lr_we     (lr_we),
  .lr_mode   (lr_mode),
  .pc_load   (pc_load),
  .flush     (flush),
  .busy      (busy)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 1'b0;
  logic exc_reset = 1'b0, exc_undef = 1'b0, exc_swi = 1'b0, exc_pabt = 1'b0, exc_dabt = 1'b0;
  logic irq_n = 1'b1, fiq_n = 1'b1;
  logic [31:0] cpsr_in = 32'h0000_0030;
  logic [31:0] next_pc = 32'h0;
  logic restore_psr = 1'b0, restore_pc = 1'b0;
  logic spsr_we, cpsr_we, lr_we, pc_load, flush, busy, restore_conflict;
  logic [4:0] spsr_mode, lr_mode;
  logic [31:0] spsr_data, cpsr_data, lr_data, pc_target;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
    .exc_reset(exc_reset), .exc_undef(exc_undef), .exc_swi(exc_swi),
    .exc_pabt(exc_pabt), .exc_dabt(exc_dabt), .irq_n(irq_n), .fiq_n(fiq_n),
    .cpsr_in(cpsr_in), .next_pc(next_pc),
    .restore_psr(restore_psr), .restore_pc(restore_pc),
    .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_data(spsr_data),
    .cpsr_we(cpsr_we), .cpsr_data(cpsr_data),
    .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
    .pc_load(pc_load), .pc_target(pc_target), .flush(flush), .busy(busy),
    .restore_conflict(restore_conflict)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      report();
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // request bits: 0 reset,1 undef,2 swi,3 pabt,4 dabt,5 irq,6 fiq
  function automatic int pick(logic [6:0] r, logic done, logic [31:0] psr);
    if (r[0]) return 0;
    if (!done) return -1;
    if (r[4]) return 4;
    if (r[6] && !psr[6]) return 7;
    if (r[5] && !psr[7]) return 6;
    if (r[3]) return 3;
    if (r[1]) return 1;
    if (r[2]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] mode_for(int k);
    case (k)
      7: return 5'b10001;
      6: return 5'b10010;
      3, 4: return 5'b10111;
      1: return 5'b11011;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] new_psr(logic [31:0] old, int k);
    logic [31:0] v;
    v = {old[31:8], 1'b1, (k == 7) ? 1'b1 : old[6], 1'b0, mode_for(k)};
    return v;
  endfunction

  task automatic drive(logic [6:0] r, logic done, logic [31:0] psr, logic [31:0] pc);
    exc_reset = r[0]; exc_undef = r[1]; exc_swi = r[2]; exc_pabt = r[3];
    exc_dabt = r[4]; irq_n = ~r[5]; fiq_n = ~r[6];
    instr_done = done; cpsr_in = psr; next_pc = pc;
  endtask

  task automatic idle_inputs();
    drive(7'b0, 1'b0, cpsr_in, next_pc);
  endtask

  task automatic trial(string name, logic [6:0] r, logic done, logic [31:0] psr, logic [31:0] pc);
    int k;
    k = pick(r, done, psr);
    @(negedge clk);
    drive(r, done, psr, pc);
    @(negedge clk);
    idle_inputs();
    if (k < 0) begin
      check({name, " R4 R8 no entry busy"}, {31'b0, busy}, 32'd0);
      check({name, " R4 R8 no spsr_we"}, {31'b0, spsr_we}, 32'd0);
    end else begin
      check({name, " R5 save step"}, {28'b0, busy, spsr_we, cpsr_we, pc_load}, 32'b1100);
      check({name, " R3 spsr_mode"}, {27'b0, spsr_mode}, {27'b0, mode_for(k)});
      check({name, " R6 spsr_data"}, spsr_data, psr);
      @(negedge clk);
      check({name, " R5 switch step"}, {28'b0, spsr_we, cpsr_we, lr_we, pc_load}, 32'b0110);
      check({name, " R7 cpsr_data"}, cpsr_data, new_psr(psr, k));
      check({name, " R6 lr_data"}, lr_data, pc);
      check({name, " R3 lr_mode"}, {27'b0, lr_mode}, {27'b0, mode_for(k)});
      @(negedge clk);
      check({name, " R5 jump step"}, {29'b0, cpsr_we, pc_load, flush}, 32'b011);
      check({name, " R2 pc_target"}, pc_target, 32'(k * 4));
      @(negedge clk);
      check({name, " R5 back idle"}, {30'b0, busy, flush}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    #1;
    check("R1 reset strobes", {26'b0, spsr_we, cpsr_we, lr_we, pc_load, flush, busy}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {26'b0, spsr_we, cpsr_we, lr_we, pc_load, flush, busy}, 32'd0);

    // directed corner cases
    trial("reset waits not R4", 7'b0000001, 1'b0, 32'h0000_0030, 32'h100);
    trial("undef needs done R4", 7'b0000010, 1'b0, 32'h0000_0030, 32'h104);
    trial("undef R2", 7'b0000010, 1'b1, 32'h0000_0030, 32'h108);
    trial("swi R2", 7'b0000100, 1'b1, 32'h0000_0010, 32'h10C);
    trial("pabt R2", 7'b0001000, 1'b1, 32'h0000_0010, 32'h110);
    trial("irq masked R8", 7'b0100000, 1'b1, 32'h0000_0090, 32'h114);
    trial("fiq masked R8", 7'b1000000, 1'b1, 32'h0000_0050, 32'h118);
    trial("fiq with I set R8", 7'b1000000, 1'b1, 32'h0000_0090, 32'h11C);
    trial("irq with F set R8", 7'b0100000, 1'b1, 32'h0000_0050, 32'h120);
    trial("all R9", 7'b1111111, 1'b1, 32'h0000_0010, 32'h124);
    trial("dabt over fiq R9", 7'b1111110, 1'b1, 32'h0000_0010, 32'h128);
    trial("fiq over irq R9", 7'b1101110, 1'b1, 32'hF000_0030, 32'h12C);
    trial("irq over pabt R9", 7'b0101110, 1'b1, 32'h0000_0030, 32'h130);
    trial("pabt over undef R9", 7'b0001110, 1'b1, 32'h0000_0030, 32'h134);
    trial("undef over swi R9", 7'b0000110, 1'b1, 32'h0000_0030, 32'h138);

    // R4 request held through a sequence is not taken twice mid-sequence
    @(negedge clk);
    drive(7'b0010000, 1'b1, 32'h0000_0010, 32'h200);
    @(negedge clk);
    @(negedge clk);
    check("R4 held request ignored while busy", {31'b0, spsr_we}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    idle_inputs();
    check("R4 busy drops after jump", {31'b0, busy}, 32'd0);
    @(negedge clk);

    // R10 restore flag
    restore_psr = 1'b1; restore_pc = 1'b0; #1;
    check("R10 psr alone", {31'b0, restore_conflict}, 32'd1);
    restore_pc = 1'b1; #1;
    check("R10 psr with pc", {31'b0, restore_conflict}, 32'd0);
    restore_psr = 1'b0; #1;
    check("R10 pc alone", {31'b0, restore_conflict}, 32'd0);
    restore_pc = 1'b0;

    // random rounds
    for (int i = 0; i < 300; i++) begin
      logic [6:0] r;
      logic [31:0] psr;
      r[0] = ($urandom % 16) == 0;
      for (int b = 1; b < 7; b++) r[b] = ($urandom % 4) == 0;
      psr = {$urandom, 5'b10000} ;
      psr[7:5] = 3'($urandom);
      psr[4:0] = 5'b10000;
      trial("random R9", r, ($urandom % 4) != 0, psr, $urandom & 32'hFFFF_FFFC);
    end
    report();
  end
endmodule